// File: doc/BRIEF.md
# Three-Port Registered Data Exchange

This block joins three data ports, numbered 0, 1 and 2, and each port is 16 bits wide by default. Each port has its own storage element, and each port's output can be driven with stored or live data taken from either of the other two ports. A storage element works in one of three modes. In transparent mode the input passes straight through. In hold mode the stored word keeps its value. In capture mode the input is taken at the port's own clock event. One source port can feed both of the other ports at the same time, so one word can be broadcast while the other ports still exchange stored data.

The block models tri-state behaviour with a separate data output and drive-enable output for each port. The surrounding pad logic combines the two. Each port has an active-low output enable. A shared control input decides how that enable acts. With the control high, the enable acts at once. With the control low, the enable is sampled into a register on each clock and acts from the next cycle. The whole block runs on one clock. Each port's own clock event is modelled as a one-cycle tick that is qualified with that port's clock enable.

Top module: `tri_port_exchange`

## Requirements
- R1: While `rst` is high on a rising clock edge, every stored word is cleared to zero and every registered enable goes to the not-driving state. After that edge, with `oe_mode` low and all latch enables low, every `port_drv` bit is 0 and every `port_out` word that selects stored data reads 0.
- R2: While `le[p]` is high, the stored view of port p equals `port_in[p]` in the same cycle, and the stored word takes that value on the clock edge.
- R3: While `le[p]` is low, `cke_n[p]` is low and `tick[p]` is high, the stored word of port p takes `port_in[p]` on the rising clock edge.
- R4: While `le[p]` is low and either `cke_n[p]` is high or `tick[p]` is low, the stored word of port p keeps its value across the clock edge.
- R5: The `sel[p]` encoding uses next = (p+1) mod 3 and prev = (p+2) mod 3. The code 0 gives `port_out[p]` the stored view of next, 1 gives the stored view of prev, 2 gives the live input of next, and 3 gives the live input of prev.
- R6: One source port can be routed to both other ports in the same cycle. With the routing selects set to 3 on port 1 and 2 on port 2, both ports show `port_in[0]`.
- R7: While `oe_mode` is high, `port_drv[p]` equals the inverse of `oe_n[p]` in the same cycle.
- R8: While `oe_mode` is low, `port_drv[p]` equals the inverse of an enable register. That register loads `oe_n[p]` on each clock edge while `oe_mode` is low and keeps its value while `oe_mode` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| port_in | input | 3x16 | Live input word of each port |
| le | input | 3 | Per-port latch enable, transparent when high |
| cke_n | input | 3 | Per-port clock enable, active low |
| tick | input | 3 | Per-port clock event, one cycle wide |
| sel | input | 3x2 | Per-port routing select |
| oe_n | input | 3 | Per-port output enable, active low |
| oe_mode | input | 1 | High: direct enable; low: registered enable |
| port_out | output | 3x16 | Data presented to each port's pads |
| port_drv | output | 3 | High where the port drives its pads |

## Verification
The bench builds the block with the default width of 16, so every transfer uses full 16-bit random words. A stuck or swapped bit anywhere in the storage or routing paths therefore shows as a mismatch. The port count stays at three, which brings every next/prev pairing of the select encoding within reach. Every combination of latch enable, clock enable and tick is also reached on each port. The random phase switches `oe_mode` freely, so the hand-over between direct and registered enables is covered.

// File: rtl/txc_pkg.sv
package txc_pkg;
  localparam int unsigned NPORT = 3;
  typedef enum logic [1:0] {
    SEL_HELD_NEXT = 2'd0,
    SEL_HELD_PREV = 2'd1,
    SEL_LIVE_NEXT = 2'd2,
    SEL_LIVE_PREV = 2'd3
  } route_sel_e;
endpackage

// File: rtl/port_store.sv
module port_store #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         le,
  input  logic         cke_n,
  input  logic         tick,
  input  logic [W-1:0] d,
  output logic [W-1:0] q,
  output logic [W-1:0] view
);
  logic take;
  assign take = le | (~cke_n & tick);

  always_ff @(posedge clk) begin
    if (rst)       q <= '0;
    else if (take) q <= d;
  end

  // transparent path: the live word is seen in the same cycle
  assign view = le ? d : q;

  a_r1_clear: assert property (@(posedge clk) rst |=> (q == '0));
  a_r2_follow: assert property (@(posedge clk) disable iff (rst)
    le |=> (q == $past(d)));
  a_r3_capture: assert property (@(posedge clk) disable iff (rst)
    (!le && !cke_n && tick) |=> (q == $past(d)));
  a_r4_hold: assert property (@(posedge clk) disable iff (rst)
    (!le && (cke_n || !tick)) |=> $stable(q));
endmodule

// File: rtl/oe_ctrl.sv
module oe_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic oe_mode,
  input  logic oe_n,
  output logic drv
);
  logic oe_q;

  always_ff @(posedge clk) begin
    if (rst)           oe_q <= 1'b1;
    else if (!oe_mode) oe_q <= oe_n;
  end

  assign drv = oe_mode ? ~oe_n : ~oe_q;

  a_r1_off: assert property (@(posedge clk) rst |=> oe_q);
  a_r8_sampled: assert property (@(posedge clk) disable iff (rst)
    !oe_mode |=> (oe_mode || (drv == !$past(oe_n))));
  a_r8_keep: assert property (@(posedge clk) disable iff (rst)
    oe_mode |=> $stable(oe_q));
endmodule

// File: rtl/route_mux.sv
module route_mux
  import txc_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic [1:0]   sel,
  input  logic [W-1:0] held_next,
  input  logic [W-1:0] held_prev,
  input  logic [W-1:0] live_next,
  input  logic [W-1:0] live_prev,
  output logic [W-1:0] y
);
  always_comb begin
    unique case (route_sel_e'(sel))
      SEL_HELD_NEXT: y = held_next;
      SEL_HELD_PREV: y = held_prev;
      SEL_LIVE_NEXT: y = live_next;
      SEL_LIVE_PREV: y = live_prev;
      default:       y = '0;
    endcase
  end
endmodule

// File: rtl/tri_port_exchange.sv
module tri_port_exchange
  import txc_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NPORT-1:0][W-1:0] port_in,
  input  logic [NPORT-1:0]        le,
  input  logic [NPORT-1:0]        cke_n,
  input  logic [NPORT-1:0]        tick,
  input  logic [NPORT-1:0][1:0]   sel,
  input  logic [NPORT-1:0]        oe_n,
  input  logic                    oe_mode,
  output logic [NPORT-1:0][W-1:0] port_out,
  output logic [NPORT-1:0]        port_drv
);
  logic [NPORT-1:0][W-1:0] held_q;
  logic [NPORT-1:0][W-1:0] held_view;

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    localparam int unsigned NX = (p + 1) % NPORT;
    localparam int unsigned PV = (p + 2) % NPORT;

    port_store #(.W(W)) u_store (
      .clk(clk), .rst(rst), .le(le[p]), .cke_n(cke_n[p]), .tick(tick[p]),
      .d(port_in[p]), .q(held_q[p]), .view(held_view[p])
    );

    route_mux #(.W(W)) u_mux (
      .sel(sel[p]),
      .held_next(held_view[NX]), .held_prev(held_view[PV]),
      .live_next(port_in[NX]),   .live_prev(port_in[PV]),
      .y(port_out[p])
    );

    oe_ctrl u_oe (
      .clk(clk), .rst(rst), .oe_mode(oe_mode), .oe_n(oe_n[p]),
      .drv(port_drv[p])
    );

    a_r7_direct: assert property (@(posedge clk) disable iff (rst)
      oe_mode |-> (port_drv[p] == !oe_n[p]));
    a_r5_live_next: assert property (@(posedge clk) disable iff (rst)
      (sel[p] == 2'd2) |-> (port_out[p] == port_in[NX]));
  end
endmodule

// File: tb/sim_tri_port_exchange.sv
module sim_tri_port_exchange;
  localparam int W = 16;
  localparam int NP = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NP-1:0][W-1:0] port_in = '0;
  logic [NP-1:0] le = '0, cke_n = '1, tick = '0, oe_n = '1;
  logic [NP-1:0][1:0] sel = '0;
  logic oe_mode = 1'b0;
  logic [NP-1:0][W-1:0] port_out;
  logic [NP-1:0] port_drv;

  tri_port_exchange #(.W(W)) u0 (
    .clk(clk), .rst(rst), .port_in(port_in), .le(le), .cke_n(cke_n),
    .tick(tick), .sel(sel), .oe_n(oe_n), .oe_mode(oe_mode),
    .port_out(port_out), .port_drv(port_drv)
  );

  always #4 clk = ~clk;

  int total = 0, bad = 0;
  bit done = 0;
  logic [W-1:0] m_st [NP];
  bit m_oe [NP];

  function automatic logic [W-1:0] seen(int p);
    return le[p] ? port_in[p] : m_st[p];
  endfunction

  task automatic compare(string tag);
    for (int p = 0; p < NP; p++) begin
      int nx = (p + 1) % NP;
      int pv = (p + 2) % NP;
      logic [W-1:0] ed;
      bit ee;
      case (sel[p])
        2'd0: ed = seen(nx);
        2'd1: ed = seen(pv);
        2'd2: ed = port_in[nx];
        default: ed = port_in[pv];
      endcase
      ee = oe_mode ? !oe_n[p] : !m_oe[p];
      total++;
      if (port_out[p] !== ed) begin
        bad++;
        $display("FAIL %s/R5 port%0d data act=%h exp=%h", tag, p, port_out[p], ed);
      end
      total++;
      if (port_drv[p] !== ee) begin
        bad++;
        $display("FAIL %s/%s port%0d drv act=%b exp=%b", tag,
                 oe_mode ? "R7" : "R8", p, port_drv[p], ee);
      end
    end
  endtask

  // drive at negedge, compare before posedge, then advance the model
  task automatic step(string tag, bit chk);
    #2;
    if (chk) compare(tag);
    @(posedge clk);
    for (int p = 0; p < NP; p++) begin
      if (rst) begin m_st[p] = '0; m_oe[p] = 1; end
      else begin
        if (le[p] || (!cke_n[p] && tick[p])) m_st[p] = port_in[p];
        if (!oe_mode) m_oe[p] = oe_n[p];
      end
    end
    @(negedge clk);
  endtask

  task automatic rnd_data();
    for (int p = 0; p < NP; p++) port_in[p] = W'($urandom);
  endtask

  initial begin
    for (int p = 0; p < NP; p++) begin m_st[p] = '0; m_oe[p] = 1; end
    @(negedge clk);
    rst = 1; rnd_data();
    step("R1", 0); step("R1", 1);
    rst = 0;
    // R1: after reset, stored data zero and no port driving
    sel = '{2'd1, 2'd0, 2'd0}; step("R1", 1);
    // R2: transparent path, stored view follows live input
    for (int i = 0; i < 6; i++) begin
      le = '1; rnd_data(); sel = '{2'($urandom), 2'($urandom & 1), 2'($urandom & 1)};
      step("R2", 1);
    end
    // R4: hold with clock enable off, or no tick
    le = '0;
    for (int i = 0; i < 8; i++) begin
      rnd_data(); cke_n = (i % 2) ? '1 : '0; tick = (i % 2) ? '1 : '0;
      sel = '{2'($urandom & 1), 2'($urandom & 1), 2'($urandom & 1)};
      step("R4", 1);
    end
    // R3: edge capture
    for (int i = 0; i < 6; i++) begin
      rnd_data(); cke_n = '0; tick = 3'($urandom);
      sel = '{2'($urandom & 1), 2'($urandom & 1), 2'($urandom & 1)};
      step("R3", 1);
    end
    // R6: port 0 broadcast to ports 1 and 2
    for (int i = 0; i < 4; i++) begin
      rnd_data(); sel = '{2'd2, 2'd3, 2'($urandom)};
      step("R6", 1);
      total++;
      if (port_out[1] !== port_in[0] || port_out[2] !== port_in[0]) begin
        bad++;
        $display("FAIL R6 act=%h/%h exp=%h", port_out[1], port_out[2], port_in[0]);
      end
    end
    // R7: direct enable
    oe_mode = 1;
    for (int i = 0; i < 6; i++) begin oe_n = 3'($urandom); step("R7", 1); end
    // R8: registered enable
    oe_mode = 0;
    for (int i = 0; i < 8; i++) begin oe_n = 3'($urandom); step("R8", 1); end
    // R5: free random mix of all controls
    for (int i = 0; i < 400; i++) begin
      rnd_data(); le = 3'($urandom); cke_n = 3'($urandom); tick = 3'($urandom);
      sel = '{2'($urandom), 2'($urandom), 2'($urandom)};
      oe_n = 3'($urandom); oe_mode = 1'($urandom);
      step("R5", 1);
    end
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule